// File: doc/BRIEF.md
# Flash command interface state machine

This block is a synthesizable behavioural model of the command decoder and write automation found in a boot-block NOR flash. A host issues bus write cycles (chip enable and write enable high together, with a word address and an 8-bit code or data byte). Two-cycle sequences start a block erase or a word program. While one of them runs, the host can suspend it, read or issue other commands, and resume it later. During an erase suspend, a program to a different block may be nested.

An 8-bit status register reports readiness, suspension and error flags, and a read-mode output tells the surrounding read path whether reads return status or array data. An open-drain ready/busy line is modelled by a pull-low enable. Write protection is decided when a command is accepted, from the supply-ok flag, a write-protect input and a three-level reset/power-down input. Operation durations come from parameterised cycle counters. Array contents are not modelled, so program data is accepted and discarded.

The address space is 19-bit words in a top-boot layout. Blocks 0 to 14 are 32K-word main blocks. Blocks 15 to 20 are 4K-word parameter blocks. Blocks 21 and 22 are the 4K-word boot blocks at 0x7E000 to 0x7FFFF.

Top module: `flash_cmd_fsm`

## Requirements
- R1: The sequence 0x20 followed by 0xD0 starts an erase. The erase holds status bit 7 at 0 for exactly ERASE_CYCLES cycles, starting in the cycle after the confirm write, and then status reads 0x80 if no flags were set before.
- R2: If any code other than 0xD0 follows 0x20, status bits 5 and 4 are both set, no operation starts, and the block returns to ready.
- R3: A write of 0x40 or 0x10, followed by one more write carrying address and data, starts a program that is busy for exactly PROG_CYCLES cycles.
- R4: A 0xB0 write during a busy erase or program suspends it on the next cycle. The block becomes ready, sets bit 6 (erase) or bit 2 (program), and releases ready/busy. A later 0xD0 resumes the operation, which then finishes its remaining cycles. A 0xB0 that arrives in the last busy cycle lets the operation complete unsuspended. While suspended, 0xFF selects array reads without leaving the suspend.
- R5: During an erase suspend, 0x40 or 0x10 followed by a write to another block runs a program. The program is busy for PROG_CYCLES cycles with bit 6 held, and the erase stays suspended afterwards. A nested program that targets the suspended block sets bit 4 and does not run.
- R6: The supply-ok flag is sampled only when an erase or program is accepted. When it is low, bit 3 is set together with bit 5 (erase) or bit 4 (program), and nothing runs. A drop of the flag while an operation runs has no effect.
- R7: rp_level encodes 00 = low, 01 = normal high and 1x = high voltage. The two boot blocks are locked only when rp_level is 01 and wp_n is 0. An erase or program of a locked block sets bit 1 and does not run. Parameter blocks, high voltage on rp_level, and wp_n = 1 all leave blocks unlocked.
- R8: Bits 5, 4, 3 and 1 are sticky. They accumulate across operations, survive 0xFF and successful operations, and clear only on 0x50, reset or rp_level low.
- R9: While rp_level is 00 the block aborts any operation, holds status at 0x80 with array-read mode and ready/busy released, and ignores bus writes.
- R10: rd_status is 1 after 0x70 and after any accepted erase, program or resume command. It is 0 after 0xFF or any unrecognised single-cycle code. 0x50 leaves it unchanged.
- R11: Status layout is: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply abort, bit 2 program suspended, bit 1 protect abort, bit 0 always 0. rb_pull_low is 1 exactly when bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| we | input | 1 | Write enable, active high; a bus write is ce and we together in a cycle |
| addr | input | ADDR_W | Word address of the bus write |
| wdata | input | 8 | Command code or program data |
| rp_level | input | 2 | Reset/power-down level: 00 low, 01 normal, 1x high voltage |
| wp_n | input | 1 | Write protect, active low |
| vpp_ok | input | 1 | Programming supply in range |
| status | output | 8 | Status register |
| rd_status | output | 1 | 1 = reads return status, 0 = reads return array data |
| rb_pull_low | output | 1 | Ready/busy open-drain pull-down enable (1 = busy) |

## Verification
On every cycle the assertions check several properties: ready/busy agrees with status bit 7, the reserved bit stays 0, the two suspend flags are never set together, and a sticky flag falls only after a clear command or a reset. They also check that reset/power-down forces status 0x80 with array mode, that a 0xB0 during a plain busy operation releases ready/busy, and that busy never rises without a bus write. Other behaviour depends on a whole command history, and only the bench scenarios can show it. This covers the exact busy lengths, the count left over after a suspend and resume, the last-cycle suspend race, nested programs and the same-block rejection, supply and protection sampling at acceptance only, and the accumulation of sticky flags.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // ready, no sequence open
    ST_ESET,   // erase setup seen, waiting for confirm
    ST_PSET,   // program setup seen, waiting for address/data
    ST_ERASE,  // erase running
    ST_PROG,   // program running
    ST_ESUSP,  // erase suspended
    ST_PSUSP,  // program suspended
    ST_EPSET,  // program setup inside erase suspend
    ST_EPROG   // program running inside erase suspend
  } fsm_t;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_PROG_A      = 8'h40;
  localparam logic [7:0] CMD_PROG_B      = 8'h10;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  localparam logic [1:0] RP_LOW    = 2'b00;
  localparam logic [1:0] RP_NORMAL = 2'b01;

endpackage

// File: rtl/flash_blk_decode.sv
module flash_blk_decode #(
  parameter int ADDR_W      = 19,
  parameter int BIG_SHIFT   = 15,
  parameter int SMALL_SHIFT = 12,
  parameter int BOOT_COUNT  = 2,
  parameter int BLK_W       = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              is_boot
);
  localparam int TOP_W    = ADDR_W - BIG_SHIFT;
  localparam int SUB_W    = BIG_SHIFT - SMALL_SHIFT;
  localparam int LAST_BIG = (2 ** TOP_W) - 1;
  localparam int unsigned BOOT_BASE = (32'd1 << ADDR_W) - BOOT_COUNT * (32'd1 << SMALL_SHIFT);

  logic [TOP_W-1:0] top_part;
  logic [SUB_W-1:0] sub_part;

  assign top_part = addr[ADDR_W-1:BIG_SHIFT];
  assign sub_part = addr[BIG_SHIFT-1:SMALL_SHIFT];

  // The last big-block slot is split into small blocks numbered after the main blocks
  always_comb begin
    if (top_part == TOP_W'(LAST_BIG)) blk_idx = BLK_W'(LAST_BIG) + BLK_W'(sub_part);
    else                              blk_idx = BLK_W'(top_part);
  end

  assign is_boot = (32'(addr) >= BOOT_BASE);
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 6,
  parameter int LEN   = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic zero
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load)                  cnt_q <= LOAD_VAL;
    else if (step && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int BIG_SHIFT    = 15,
  parameter int SMALL_SHIFT  = 12,
  parameter int BOOT_COUNT   = 2,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [1:0]        rp_level,
  input  logic              wp_n,
  input  logic              vpp_ok,
  output logic [7:0]        status,
  output logic              rd_status,
  output logic              rb_pull_low
);
  localparam int SUB_W     = BIG_SHIFT - SMALL_SHIFT;
  localparam int BLK_COUNT = (2 ** (ADDR_W - BIG_SHIFT)) - 1 + (2 ** SUB_W);
  localparam int BLK_W     = $clog2(BLK_COUNT);
  localparam int MAX_LEN   = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  fsm_t st_q, st_n;
  logic mode_q, mode_n;
  logic e_err_q, e_err_n, p_err_q, p_err_n, vpp_q, vpp_n, prot_q, prot_n;
  logic [BLK_W-1:0] eblk_q, eblk_n, blk;
  logic is_boot, locked, wr, misc_cmd, busy_n;
  logic e_zero, p_zero, e_load, e_step, p_load, p_step;
  logic [7:0] status_n;

  flash_blk_decode #(
    .ADDR_W(ADDR_W), .BIG_SHIFT(BIG_SHIFT), .SMALL_SHIFT(SMALL_SHIFT),
    .BOOT_COUNT(BOOT_COUNT), .BLK_W(BLK_W)
  ) u_dec (
    .addr(addr), .blk_idx(blk), .is_boot(is_boot)
  );

  flash_op_timer #(.CNT_W(CNT_W), .LEN(ERASE_CYCLES)) u_erase_tmr (
    .clk(clk), .rst(rst), .load(e_load), .step(e_step), .zero(e_zero)
  );

  flash_op_timer #(.CNT_W(CNT_W), .LEN(PROG_CYCLES)) u_prog_tmr (
    .clk(clk), .rst(rst), .load(p_load), .step(p_step), .zero(p_zero)
  );

  assign wr     = ce && we;
  assign locked = (rp_level == RP_NORMAL) && !wp_n && is_boot;

  always_comb begin
    st_n = st_q; mode_n = mode_q; eblk_n = eblk_q;
    e_err_n = e_err_q; p_err_n = p_err_q; vpp_n = vpp_q; prot_n = prot_q;
    e_load = 1'b0; e_step = 1'b0; p_load = 1'b0; p_step = 1'b0;
    misc_cmd = 1'b0;
    case (st_q)
      ST_IDLE: if (wr) begin
        case (wdata)
          CMD_ERASE_SETUP:        begin st_n = ST_ESET; mode_n = 1'b1; end
          CMD_PROG_A, CMD_PROG_B: begin st_n = ST_PSET; mode_n = 1'b1; end
          default:                misc_cmd = 1'b1;
        endcase
      end
      ST_ESET: if (wr) begin
        mode_n = 1'b1;
        st_n   = ST_IDLE;
        if (wdata != CMD_CONFIRM) begin e_err_n = 1'b1; p_err_n = 1'b1; end
        else if (!vpp_ok)         begin vpp_n = 1'b1; e_err_n = 1'b1; end
        else if (locked)          prot_n = 1'b1;
        else begin st_n = ST_ERASE; e_load = 1'b1; eblk_n = blk; end
      end
      ST_PSET: if (wr) begin
        mode_n = 1'b1;
        st_n   = ST_IDLE;
        if (!vpp_ok)     begin vpp_n = 1'b1; p_err_n = 1'b1; end
        else if (locked) prot_n = 1'b1;
        else begin st_n = ST_PROG; p_load = 1'b1; end
      end
      ST_ERASE: begin
        if (e_zero)                           st_n = ST_IDLE;
        else if (wr && wdata == CMD_SUSPEND)  st_n = ST_ESUSP;
        else                                  e_step = 1'b1;
      end
      ST_PROG: begin
        if (p_zero)                           st_n = ST_IDLE;
        else if (wr && wdata == CMD_SUSPEND)  st_n = ST_PSUSP;
        else                                  p_step = 1'b1;
      end
      ST_ESUSP: if (wr) begin
        case (wdata)
          CMD_CONFIRM:            begin st_n = ST_ERASE; mode_n = 1'b1; end
          CMD_PROG_A, CMD_PROG_B: begin st_n = ST_EPSET; mode_n = 1'b1; end
          default:                misc_cmd = 1'b1;
        endcase
      end
      ST_PSUSP: if (wr) begin
        if (wdata == CMD_CONFIRM) begin st_n = ST_PROG; mode_n = 1'b1; end
        else                      misc_cmd = 1'b1;
      end
      ST_EPSET: if (wr) begin
        mode_n = 1'b1;
        st_n   = ST_ESUSP;
        if (!vpp_ok)            begin vpp_n = 1'b1; p_err_n = 1'b1; end
        else if (locked)        prot_n = 1'b1;
        else if (blk == eblk_q) p_err_n = 1'b1;
        else begin st_n = ST_EPROG; p_load = 1'b1; end
      end
      ST_EPROG: begin
        if (p_zero) st_n = ST_ESUSP;
        else        p_step = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase

    if (misc_cmd) begin
      case (wdata)
        CMD_READ_STATUS: mode_n = 1'b1;
        CMD_CLEAR:       begin e_err_n = 1'b0; p_err_n = 1'b0; vpp_n = 1'b0; prot_n = 1'b0; end
        CMD_READ_ARRAY:  mode_n = 1'b0;
        default:         mode_n = 1'b0;
      endcase
    end

    if (rp_level == RP_LOW) begin
      st_n = ST_IDLE; mode_n = 1'b0;
      e_err_n = 1'b0; p_err_n = 1'b0; vpp_n = 1'b0; prot_n = 1'b0;
      e_load = 1'b0; e_step = 1'b0; p_load = 1'b0; p_step = 1'b0;
    end

    busy_n   = (st_n == ST_ERASE) || (st_n == ST_PROG) || (st_n == ST_EPROG);
    status_n = {!busy_n,
                (st_n == ST_ESUSP) || (st_n == ST_EPSET) || (st_n == ST_EPROG),
                e_err_n, p_err_n, vpp_n,
                (st_n == ST_PSUSP),
                prot_n, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; mode_q <= 1'b0; eblk_q <= '0;
      e_err_q <= 1'b0; p_err_q <= 1'b0; vpp_q <= 1'b0; prot_q <= 1'b0;
      status <= 8'h80; rd_status <= 1'b0; rb_pull_low <= 1'b0;
    end else begin
      st_q <= st_n; mode_q <= mode_n; eblk_q <= eblk_n;
      e_err_q <= e_err_n; p_err_q <= p_err_n; vpp_q <= vpp_n; prot_q <= prot_n;
      status <= status_n; rd_status <= mode_n; rb_pull_low <= busy_n;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       we,
  input logic [7:0] wdata,
  input logic [1:0] rp_level,
  input logic [7:0] status,
  input logic       rd_status,
  input logic       rb_pull_low
);
  // R11: the ready/busy pull-down agrees with the ready bit
  a_r11_rb_tracks_ready: assert property (@(posedge clk) disable iff (rst)
    rb_pull_low == !status[7]);

  // R11: the reserved bit always reads 0
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !status[0]);

  // R9: power-down forces ready, no flags and array mode
  a_r9_rp_low_resets: assert property (@(posedge clk) disable iff (rst)
    (rp_level == 2'b00) |=> (status == 8'h80 && !rd_status && !rb_pull_low));

  // R4: erase suspend and program suspend are never reported together
  a_r4_single_suspend: assert property (@(posedge clk) disable iff (rst)
    !(status[6] && status[2]));

  // R4: a suspend request during a plain busy operation releases busy next cycle
  a_r4_suspend_releases: assert property (@(posedge clk) disable iff (rst)
    (rb_pull_low && ce && we && wdata == 8'hB0 && !status[6]) |=> !rb_pull_low);

  // R8: a sticky flag falls only after a clear command or a reset
  a_r8_sticky_clear_only: assert property (@(posedge clk) disable iff (rst)
    ($fell(status[5]) || $fell(status[4]) || $fell(status[3]) || $fell(status[1]))
    |-> $past((ce && we && wdata == 8'h50) || rp_level == 2'b00 || rst));

  // R1: busy never starts without a bus write in the cycle before
  a_r1_busy_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_pull_low) |-> $past(ce && we));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk(clk), .rst(rst), .ce(ce), .we(we), .wdata(wdata), .rp_level(rp_level),
  .status(status), .rd_status(rd_status), .rb_pull_low(rb_pull_low)
);

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  localparam int EC = 20;
  localparam int PC = 6;
  localparam int M_IDLE = 0, M_ESET = 1, M_PSET = 2, M_ERASE = 3, M_PROG = 4,
                 M_ESUSP = 5, M_PSUSP = 6, M_EPSET = 7, M_EPROG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] rp_level = 2'b01;
  logic wp_n = 1'b1, vpp_ok = 1'b1;
  logic [7:0] status;
  logic rd_status, rb_pull_low;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R11";

  flash_cmd_fsm #(.ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_flash_cmd_fsm (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr), .wdata(wdata),
    .rp_level(rp_level), .wp_n(wp_n), .vpp_ok(vpp_ok),
    .status(status), .rd_status(rd_status), .rb_pull_low(rb_pull_low)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int ms = M_IDLE, mce = 0, mcp = 0, meblk = 0;
  bit mmode = 0, mb5 = 0, mb4 = 0, mb3 = 0, mb1 = 0;

  function automatic int blk_of(int a);
    if ((a >> 15) < 15) return a >> 15;
    return 15 + ((a >> 12) & 7);
  endfunction

  function automatic bit boot_of(int a);
    return a >= 32'h7E000;
  endfunction

  function automatic logic [7:0] m_status();
    bit busy = (ms == M_ERASE) || (ms == M_PROG) || (ms == M_EPROG);
    bit es = (ms == M_ESUSP) || (ms == M_EPSET) || (ms == M_EPROG);
    return {!busy, es, mb5, mb4, mb3, (ms == M_PSUSP), mb1, 1'b0};
  endfunction

  task automatic m_misc(int d);
    if (d == 8'h70) mmode = 1;
    else if (d == 8'h50) begin mb5 = 0; mb4 = 0; mb3 = 0; mb1 = 0; end
    else mmode = 0;
  endtask

  always @(posedge clk) begin
    bit w;
    int a, d;
    bit lk;
    w = ce && we; a = int'(addr); d = int'(wdata);
    lk = (rp_level == 2'b01) && !wp_n && boot_of(a);
    if (rst || rp_level == 2'b00) begin
      ms = M_IDLE; mmode = 0; mb5 = 0; mb4 = 0; mb3 = 0; mb1 = 0;
    end else begin
      case (ms)
        M_IDLE: if (w) begin
          if (d == 8'h20) begin ms = M_ESET; mmode = 1; end
          else if (d == 8'h40 || d == 8'h10) begin ms = M_PSET; mmode = 1; end
          else m_misc(d);
        end
        M_ESET: if (w) begin
          mmode = 1; ms = M_IDLE;
          if (d != 8'hD0) begin mb5 = 1; mb4 = 1; end
          else if (!vpp_ok) begin mb3 = 1; mb5 = 1; end
          else if (lk) mb1 = 1;
          else begin ms = M_ERASE; mce = EC - 1; meblk = blk_of(a); end
        end
        M_PSET: if (w) begin
          mmode = 1; ms = M_IDLE;
          if (!vpp_ok) begin mb3 = 1; mb4 = 1; end
          else if (lk) mb1 = 1;
          else begin ms = M_PROG; mcp = PC - 1; end
        end
        M_ERASE: begin
          if (mce == 0) ms = M_IDLE;
          else if (w && d == 8'hB0) ms = M_ESUSP;
          else mce--;
        end
        M_PROG: begin
          if (mcp == 0) ms = M_IDLE;
          else if (w && d == 8'hB0) ms = M_PSUSP;
          else mcp--;
        end
        M_ESUSP: if (w) begin
          if (d == 8'hD0) begin ms = M_ERASE; mmode = 1; end
          else if (d == 8'h40 || d == 8'h10) begin ms = M_EPSET; mmode = 1; end
          else m_misc(d);
        end
        M_PSUSP: if (w) begin
          if (d == 8'hD0) begin ms = M_PROG; mmode = 1; end
          else m_misc(d);
        end
        M_EPSET: if (w) begin
          mmode = 1; ms = M_ESUSP;
          if (!vpp_ok) begin mb3 = 1; mb4 = 1; end
          else if (lk) mb1 = 1;
          else if (blk_of(a) == meblk) mb4 = 1;
          else begin ms = M_EPROG; mcp = PC - 1; end
        end
        M_EPROG: begin
          if (mcp == 0) ms = M_ESUSP;
          else mcp--;
        end
        default: ms = M_IDLE;
      endcase
    end
  end

  // ---------------- checks ----------------
  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "cycle status", status, m_status());
      chk(cur_req, "cycle rd_status", {7'd0, rd_status}, {7'd0, mmode});
      chk(cur_req, "cycle ready/busy", {7'd0, rb_pull_low}, {7'd0, !m_status()[7]});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  // All tasks start and end at a falling edge
  task automatic wr_cmd(int a, int d);
    ce = 1; we = 1; addr = 19'(a); wdata = 8'(d);
    @(negedge clk);
    ce = 0; we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    cur_req = "R9";
    chk("R9", "reset status", status, 8'h80);
    chk("R9", "reset mode", {7'd0, rd_status}, 8'h00);
    chk("R11", "reset ready/busy", {7'd0, rb_pull_low}, 8'h00);

    // R10: read mode selection
    cur_req = "R10";
    wr_cmd(0, 8'h70); chk("R10", "status mode", {7'd0, rd_status}, 8'h01);
    wr_cmd(0, 8'h33); chk("R10", "unknown code to array", {7'd0, rd_status}, 8'h00);
    wr_cmd(0, 8'h70); wr_cmd(0, 8'hFF); chk("R10", "read array", {7'd0, rd_status}, 8'h00);

    // R1: erase of a main block
    cur_req = "R1";
    wr_cmd(32'h08000, 8'h20); wr_cmd(32'h08123, 8'hD0);
    chk("R1", "busy after confirm", status, 8'h00);
    chk("R11", "pull low while busy", {7'd0, rb_pull_low}, 8'h01);
    idle(EC - 1); chk("R1", "still busy last cycle", status, 8'h00);
    idle(1); chk("R1", "erase done", status, 8'h80);
    chk("R10", "status mode after op", {7'd0, rd_status}, 8'h01);

    // R2 and R8: bad sequence, sticky across ops
    cur_req = "R2";
    wr_cmd(0, 8'h20); wr_cmd(0, 8'h40);
    chk("R2", "bad sequence flags", status, 8'hB0);
    cur_req = "R8";
    wr_cmd(0, 8'hFF); chk("R8", "sticky after read array", status, 8'hB0);
    wr_cmd(0, 8'h40); wr_cmd(32'h100, 8'h5A); idle(PC);
    chk("R8", "sticky after good program", status, 8'hB0);
    wr_cmd(0, 8'h50); chk("R8", "clear command", status, 8'h80);

    // R3: both program setup codes
    cur_req = "R3";
    wr_cmd(0, 8'h10); wr_cmd(32'h20000, 8'hA5);
    idle(PC - 1); chk("R3", "program busy last cycle", status, 8'h00);
    idle(1); chk("R3", "program done", status, 8'h80);
    wr_cmd(0, 8'h40); wr_cmd(32'h30000, 8'h11);
    chk("R3", "program busy", status, 8'h00);
    idle(PC);

    // R4: erase suspend and resume
    cur_req = "R4";
    wr_cmd(0, 8'h20); wr_cmd(0, 8'hD0); idle(3);
    wr_cmd(0, 8'hB0); chk("R4", "erase suspended", status, 8'hC0);
    chk("R4", "suspend releases busy", {7'd0, rb_pull_low}, 8'h00);
    idle(5); wr_cmd(0, 8'hFF);
    chk("R4", "array mode in suspend", {7'd0, rd_status}, 8'h00);
    chk("R4", "still suspended", status, 8'hC0);
    wr_cmd(0, 8'hD0); chk("R4", "resumed busy", status, 8'h00);
    idle(EC - 4); chk("R4", "remaining count busy", status, 8'h00);
    idle(1); chk("R4", "resumed erase done", status, 8'h80);
    // program suspend
    wr_cmd(0, 8'h40); wr_cmd(32'h40000, 8'h00); idle(1);
    wr_cmd(0, 8'hB0); chk("R4", "program suspended", status, 8'h84);
    wr_cmd(0, 8'hD0); idle(PC); chk("R4", "program resumed done", status, 8'h80);
    // suspend in last busy cycle completes instead
    wr_cmd(0, 8'h20); wr_cmd(0, 8'hD0); idle(EC - 1);
    wr_cmd(0, 8'hB0); chk("R4", "late suspend completes", status, 8'h80);

    // R5: program nested in erase suspend
    cur_req = "R5";
    wr_cmd(0, 8'h20); wr_cmd(0, 8'hD0); idle(2);
    wr_cmd(0, 8'hB0);
    wr_cmd(0, 8'h40); wr_cmd(32'h10000, 8'h77);
    chk("R5", "nested program busy", status, 8'h40);
    idle(PC - 1); chk("R5", "nested still busy", status, 8'h40);
    idle(1); chk("R5", "erase still suspended", status, 8'hC0);
    wr_cmd(0, 8'h10); wr_cmd(32'h00010, 8'h77);
    chk("R5", "same block rejected", status, 8'hD0);
    wr_cmd(0, 8'h50); wr_cmd(0, 8'hD0);
    chk("R5", "erase resumes", status, 8'h00);
    idle(EC); chk("R5", "erase finishes", status, 8'h80);

    // R6: supply sampled at acceptance
    cur_req = "R6";
    vpp_ok = 0;
    wr_cmd(0, 8'h20); wr_cmd(0, 8'hD0); chk("R6", "erase supply abort", status, 8'hA8);
    wr_cmd(0, 8'h50);
    wr_cmd(0, 8'h40); wr_cmd(0, 8'h01); chk("R6", "program supply abort", status, 8'h98);
    wr_cmd(0, 8'h50);
    vpp_ok = 1;
    wr_cmd(0, 8'h40); wr_cmd(0, 8'h01); vpp_ok = 0; idle(PC);
    chk("R6", "drop while running ignored", status, 8'h80);
    vpp_ok = 1;

    // R7: protection levels
    cur_req = "R7";
    wp_n = 0;
    wr_cmd(0, 8'h20); wr_cmd(32'h7F000, 8'hD0); chk("R7", "boot locked", status, 8'h82);
    wr_cmd(0, 8'h50);
    wr_cmd(0, 8'h40); wr_cmd(32'h78000, 8'h01); chk("R7", "parameter open", status, 8'h00);
    idle(PC);
    rp_level = 2'b10;
    wr_cmd(0, 8'h20); wr_cmd(32'h7E000, 8'hD0); chk("R7", "high voltage unlocks", status, 8'h00);
    idle(EC);
    rp_level = 2'b01; wp_n = 1;
    wr_cmd(0, 8'h40); wr_cmd(32'h7E000, 8'h01); chk("R7", "wp high unlocks", status, 8'h00);
    idle(PC); chk("R7", "boot program done", status, 8'h80);

    // R9: power-down aborts and ignores writes
    cur_req = "R9";
    vpp_ok = 0; wr_cmd(0, 8'h20); wr_cmd(0, 8'hD0); vpp_ok = 1;
    wr_cmd(0, 8'h20); wr_cmd(0, 8'hD0); idle(2);
    chk("R9", "busy with sticky", status, 8'h28);
    rp_level = 2'b00; idle(1);
    chk("R9", "power-down clears", status, 8'h80);
    chk("R9", "power-down releases busy", {7'd0, rb_pull_low}, 8'h00);
    wr_cmd(0, 8'h70);
    chk("R9", "write ignored", {7'd0, rd_status}, 8'h00);
    rp_level = 2'b01; idle(2);
    chk("R9", "array mode after exit", {7'd0, rd_status}, 8'h00);

    finish_run();
  end
endmodule